// File: doc/BRIEF.md
# Acknowledge-Sender Role Arbitration Timer

This block decides when a telephone terminal takes on the job of sending the acknowledge during an alert-signal handshake, and when that acknowledge is sent. The terminal is given a fixed role code at configuration time. It can be the primary sender, the fallback sender, a bystander that is already off hook, or a terminal that never sends. Once the alert has been detected, the block measures how long the line stays in its high state, using a 1 ms timebase tick. The line only goes high when every off-hook terminal has also seen the alert. A primary sender acts as soon as the line goes high. A fallback or bystander terminal acts only after the line has stayed high for a role-specific length of time. This lets the next terminal in line take over when the senders ahead of it do not respond.

When the role is taken, the block raises an off-hook request and a sticky role-acquired flag. It then enables acknowledge transmission 35 ms after the line went high, which is the middle of the 30 to 40 ms window that is allowed. The role is kept until a call-end pulse returns the block to idle. Tone detection, line sensing and tone generation are handled by neighbouring blocks.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ackarb_top`

## Requirements
- R1: While reset is held and directly after it, `offhook_req`, `role_acq` and `ack_en` are 0.
- R2: The block is armed by an `alert_det` pulse only in these cases: `role_code` 2'b00 (primary), 2'b01 (fallback), or 2'b10 (bystander) while `off_hook_in` is 1. With `role_code` 2'b11, or with no alert, line-high never sets any output.
- R3: For an armed primary terminal, `role_acq` and `offhook_req` rise on the clock after `line_high` rises, without waiting for a tick.
- R4: An armed fallback terminal takes the role once `line_high` has lasted 15 ticks. This is no later than 20 ms after the line went high.
- R5: An armed bystander terminal takes the role once `line_high` has lasted 30 ticks. This is no later than 35 ms after the line went high.
- R6: If `line_high` falls before the role is taken, the duration count restarts from zero. A later high period must reach the full threshold again.
- R7: Once taken, `role_acq` and `offhook_req` stay 1 whatever `line_high` does, until `call_end`.
- R8: `ack_en` rises only while the role is held. It rises once 35 ticks have passed since `line_high` went high, with the count continuing after the role is taken even if the line drops. It then stays 1 until `call_end`.
- R9: A `call_end` pulse clears all three outputs on the next clock and disarms the block. Line-high then has no effect until a new alert arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| line_high | input | 1 | Line is in its high state |
| off_hook_in | input | 1 | This terminal is currently off hook |
| alert_det | input | 1 | Alert signal detected (pulse) |
| role_code | input | 2 | 00 primary, 01 fallback, 10 bystander, 11 never sends |
| call_end | input | 1 | End of call: clear role and return to idle |
| offhook_req | output | 1 | Request to go off hook |
| ack_en | output | 1 | Enable acknowledge transmission |
| role_acq | output | 1 | Sticky flag: acknowledge-sender role taken |

## Verification
The assertions check several properties on every cycle. The role stays held until call end, the acknowledge is never enabled without the role, and call end clears both flags. The role never appears without arming, and the duration count returns to zero once the line drops before the role is taken. They also check that the role rises no later than the role's deadline and that the acknowledge starts exactly at the midpoint count. The exact millisecond at which each role is taken can only be shown by the bench's sweeps. So can the behaviour when the line drops after a given number of ticks, the restart after an interrupted high period, and the refusal to act after call end.

// File: rtl/ackarb_pkg.sv
package ackarb_pkg;
  typedef enum logic [1:0] {
    ROLE_PRIMARY   = 2'b00,
    ROLE_FALLBACK  = 2'b01,
    ROLE_BYSTANDER = 2'b10,
    ROLE_SILENT    = 2'b11
  } role_e;
endpackage

// File: rtl/ackarb_arm.sv
module ackarb_arm
  import ackarb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  call_end,
  input  logic  alert_det,
  input  logic  off_hook_in,
  input  role_e role,
  output logic  armed
);
  logic eligible;

  always_comb begin
    case (role)
      ROLE_PRIMARY, ROLE_FALLBACK: eligible = 1'b1;
      ROLE_BYSTANDER:              eligible = off_hook_in;
      default:                     eligible = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     armed <= 1'b0;
    else if (call_end)              armed <= 1'b0;
    else if (alert_det && eligible) armed <= 1'b1;
  end

  AST_SILENT_NEVER_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (role == ROLE_SILENT && !armed) |=> !armed); // R2
endmodule

// File: rtl/ackarb_lhctr.sv
module ackarb_lhctr #(
  parameter int MAX_MS = 35,
  localparam int CW = $clog2(MAX_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          run,
  input  logic          hold,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_MS);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (run || hold) begin
      if (tick && cnt != CMAX) cnt <= cnt + 1'b1;
    end else                 cnt <= '0;
  end

  AST_CNT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run && !hold) |=> (cnt == '0)); // R6
endmodule

// File: rtl/ackarb_role.sv
module ackarb_role
  import ackarb_pkg::*;
#(
  parameter int CW         = 6,
  parameter int PRI_MIN_MS = 0,
  parameter int PRI_DL_MS  = 5,
  parameter int FB_MIN_MS  = 15,
  parameter int FB_DL_MS   = 20,
  parameter int BYS_MIN_MS = 30,
  parameter int BYS_DL_MS  = 35,
  parameter int ACK_MS     = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_end,
  input  role_e         role,
  input  logic          armed,
  input  logic          line_high,
  input  logic [CW-1:0] cnt,
  output logic          role_acq,
  output logic          ack_en
);
  localparam logic [CW-1:0] ACK_T = CW'(ACK_MS);
  logic [CW-1:0] thr, dl;
  logic          allowed, take;

  always_comb begin
    allowed = 1'b1;
    case (role)
      ROLE_PRIMARY:   begin thr = CW'(PRI_MIN_MS); dl = CW'(PRI_DL_MS); end
      ROLE_FALLBACK:  begin thr = CW'(FB_MIN_MS);  dl = CW'(FB_DL_MS);  end
      ROLE_BYSTANDER: begin thr = CW'(BYS_MIN_MS); dl = CW'(BYS_DL_MS); end
      default:        begin thr = '1; dl = '1; allowed = 1'b0; end
    endcase
  end

  assign take = !role_acq && armed && line_high && allowed && (cnt >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n)        role_acq <= 1'b0;
    else if (call_end) role_acq <= 1'b0;
    else if (take)     role_acq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          ack_en <= 1'b0;
    else if (call_end)                   ack_en <= 1'b0;
    else if (role_acq && cnt >= ACK_T)   ack_en <= 1'b1;
  end

  AST_ROLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (role_acq && !call_end) |=> role_acq); // R7
  AST_ACK_NEEDS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_en |-> role_acq); // R8
  AST_ROLE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(role_acq) |-> $past(armed)); // R2
  AST_ROLE_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(role_acq) |-> (cnt <= dl)); // R5
  AST_ACK_AT_MIDPOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_en) |-> (cnt == ACK_T)); // R8
  AST_CALL_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    call_end |=> (!role_acq && !ack_en)); // R9
endmodule

// File: rtl/ackarb_top.sv
module ackarb_top
  import ackarb_pkg::*;
#(
  parameter int PRI_MIN_MS = 0,
  parameter int PRI_DL_MS  = 5,
  parameter int FB_MIN_MS  = 15,
  parameter int FB_DL_MS   = 20,
  parameter int BYS_MIN_MS = 30,
  parameter int BYS_DL_MS  = 35,
  parameter int ACK_MS     = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       line_high,
  input  logic       off_hook_in,
  input  logic       alert_det,
  input  logic [1:0] role_code,
  input  logic       call_end,
  output logic       offhook_req,
  output logic       ack_en,
  output logic       role_acq
);
  localparam int CW = $clog2(ACK_MS + 1);

  role_e         role;
  logic          armed;
  logic [CW-1:0] cnt;

  assign role = role_e'(role_code);

  ackarb_arm u_arm (
    .clk(clk), .rst_n(rst_n), .call_end(call_end), .alert_det(alert_det),
    .off_hook_in(off_hook_in), .role(role), .armed(armed)
  );

  ackarb_lhctr #(.MAX_MS(ACK_MS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(call_end), .tick(tick_1ms),
    .run(armed && line_high), .hold(role_acq), .cnt(cnt)
  );

  ackarb_role #(
    .CW(CW), .PRI_MIN_MS(PRI_MIN_MS), .PRI_DL_MS(PRI_DL_MS),
    .FB_MIN_MS(FB_MIN_MS), .FB_DL_MS(FB_DL_MS),
    .BYS_MIN_MS(BYS_MIN_MS), .BYS_DL_MS(BYS_DL_MS), .ACK_MS(ACK_MS)
  ) u_role (
    .clk(clk), .rst_n(rst_n), .call_end(call_end), .role(role),
    .armed(armed), .line_high(line_high), .cnt(cnt),
    .role_acq(role_acq), .ack_en(ack_en)
  );

  assign offhook_req = role_acq;

  AST_OFFHOOK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (offhook_req && !call_end) |=> offhook_req); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!offhook_req && !ack_en && !role_acq)); // R1
endmodule

// File: tb/tb_ackarb_top.sv
module tb_ackarb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 8;
  localparam int ACK_T = 35;
  localparam int NT = 40;

  logic clk = 0, rst_n = 0, tick_1ms = 0, line_high = 0, off_hook_in = 0;
  logic alert_det = 0, call_end = 0;
  logic [1:0] role_code = 0;
  logic offhook_req, ack_en, role_acq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ackarb_top dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .line_high(line_high),
    .off_hook_in(off_hook_in), .alert_det(alert_det), .role_code(role_code),
    .call_end(call_end), .offhook_req(offhook_req), .ack_en(ack_en),
    .role_acq(role_acq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_1ms = 1;
    @(negedge clk) tick_1ms = 0;
    repeat (TDIV - 2) @(negedge clk);
  endtask

  function automatic int thr_of(input int r);
    case (r)
      0: return 0;
      1: return 15;
      2: return 30;
      default: return 1000;
    endcase
  endfunction

  task automatic start(input logic [1:0] r, input logic offh, input logic alrt);
    @(negedge clk);
    rst_n = 0; line_high = 0; tick_1ms = 0; call_end = 0; alert_det = 0;
    role_code = r; off_hook_in = offh;
    repeat (3) @(negedge clk);
    chk("R1 reset role_acq", role_acq, 1'b0);
    chk("R1 reset ack_en", ack_en, 1'b0);
    rst_n = 1;
    @(negedge clk);
    alert_det = alrt;
    @(negedge clk);
    alert_det = 0;
    @(negedge clk);
  endtask

  // Line high during ticks 1..h, then low; NT ticks total
  task automatic sweep(input logic [1:0] r, input logic offh, input logic alrt,
                       input int h, input string tag);
    int thr;
    logic acq, ack;
    thr = (alrt && (r != 2'b10 || offh)) ? thr_of(int'(r)) : 1000;
    start(r, offh, alrt);
    line_high = 1;
    for (int k = 1; k <= NT; k++) begin
      if (k > h) line_high = 0;
      do_tick();
      acq = ((k < h ? k : h) >= thr);
      ack = acq && (k >= ACK_T);
      chk(tag, role_acq, acq);
      chk(tag, offhook_req, acq);
      chk("R8 ack", ack_en, ack);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R3 R4 R5 R6 R7 R8: sweep of line-high length per role
    for (int h = 1; h <= NT; h++) begin
      sweep(2'b00, 1'b0, 1'b1, h, "R3 primary");
      sweep(2'b01, 1'b0, 1'b1, h, "R4 fallback");
      sweep(2'b10, 1'b1, 1'b1, h, "R5 bystander");
    end
    // R2: arming rules
    sweep(2'b11, 1'b1, 1'b1, NT, "R2 silent");
    sweep(2'b10, 1'b0, 1'b1, NT, "R2 bystander on hook");
    sweep(2'b00, 1'b0, 1'b0, NT, "R2 no alert");
    sweep(2'b01, 1'b0, 1'b0, NT, "R2 no alert fb");

    // R6: interrupted high period restarts the count
    start(2'b10, 1'b1, 1'b1);
    line_high = 1;
    for (int k = 1; k <= 20; k++) do_tick();
    chk("R6 before drop", role_acq, 1'b0);
    line_high = 0;
    for (int k = 1; k <= 3; k++) do_tick();
    chk("R6 during drop", role_acq, 1'b0);
    line_high = 1;
    for (int j = 1; j <= 36; j++) begin
      do_tick();
      chk("R6 restart", role_acq, j >= 30);
      chk("R8 ack after restart", ack_en, j >= ACK_T);
    end
    // R9: call end clears and disarms
    @(negedge clk) call_end = 1;
    @(negedge clk) call_end = 0;
    chk("R9 role cleared", role_acq, 1'b0);
    chk("R9 offhook cleared", offhook_req, 1'b0);
    chk("R9 ack cleared", ack_en, 1'b0);
    for (int k = 1; k <= 40; k++) do_tick();
    chk("R9 disarmed role", role_acq, 1'b0);
    chk("R9 disarmed ack", ack_en, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule